// File: doc/BRIEF.md
# Keyed Write-Protection Lock

This block guards a group of configuration registers behind a persistent lock bit. The lock bit lives in a byte-wide control register. It can be changed only by a control-register write that comes right after two key writes, first 0x46 and then 0x57, made on consecutive control-register writes. Any control-register write that breaks this order sends the key sequencer back to its start. After the lock bit changes it keeps its new value. It does not relock by itself, so software can unlock once, reprogram every protected register, and then lock again with a second sequence.

While the lock is set, the block masks write requests aimed at the protected registers. Those writes complete on the bus, but the registers keep their contents. A one-way configuration input makes the lock sticky: once the lock has been set after reset, no later sequence can clear it, and only a reset releases it. A flag records whether the lock has been set at any time since reset. The control-register bits other than the lock bit behave as ordinary read/write storage. The block does not do bus decoding, and it does not hold the protected registers themselves.

Top module: `keylock_guard`

## Requirements
- R1: After reset the lock output is 0, the ever-locked flag is 0 and the control readback is 0x00.
- R2: A control write that follows the key writes 0x46 then 0x57 loads bit 6 of its data into the lock bit (1 = locked), visible on the lock output one clock after that write.
- R3: With no completed key sequence, control writes never change the lock output.
- R4: If a control write does not carry the key expected next, the sequence restarts from the beginning. A wrong first key, or a wrong or repeated second key, leaves the following write unable to change the lock.
- R5: Cycles without any control write between the keys and the lock write do not break the sequence.
- R6: Only the first control write after the second key can change the lock. The write after that cannot.
- R7: When the one-way input is 1 and the lock has been set since reset, a complete sequence does not clear the lock. Only reset clears it.
- R8: When the one-way input is 0, the lock can be cleared and set again any number of times, each time with a full sequence.
- R9: The ever-locked flag becomes 1 in the same cycle that the lock becomes 1, and it stays 1 until reset.
- R10: A control write that is not used as a key loads its data into every control bit except bit 6. A write used as a key changes no readback bit. Readback bit 6 always equals the lock.
- R11: The protected-register write enable output equals the write request input when unlocked, and 0 when locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr_en | input | 1 | Control-register write strobe |
| ctl_wr_data | input | 8 | Control-register write data |
| one_way_en | input | 1 | 1 = lock cannot be cleared once set, until reset |
| prot_wr_req | input | 1 | Write request for the protected registers |
| lock_o | output | 1 | Lock state (1 = protected registers locked) |
| lock_ever_o | output | 1 | Lock has been set since reset |
| ctl_rd_data | output | 8 | Control-register readback, lock in bit 6 |
| prot_wr_ok | output | 1 | Gated write enable for the protected registers |

## Verification
The bench drives every possible byte as the write that follows a valid key pair. This shows that only bit 6 steers the lock and that the other seven bits land in the readback. It also drives every byte in place of the first key and in place of the second key. Those sweeps separate a sequencer that restarts correctly from one that accepts near-miss keys or a repeated first key. Directed runs add idle gaps, a second write after the armed one, and repeated set/clear sessions with the one-way input at each value. These show apart a lock that persists, one that relocks, and one that a reset alone releases.

// File: rtl/keylock_pkg.sv
package keylock_pkg;
    localparam int CTRL_W = 8;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_HALF  = 2'd1,
        SEQ_ARMED = 2'd2
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
    } seq_regs_t;

    typedef struct packed {
        logic              lock;
        logic              ever;
        logic [CTRL_W-1:0] bits;
    } hold_regs_t;
endpackage

// File: rtl/keylock_seq.sv
module keylock_seq
    import keylock_pkg::*;
#(
    parameter logic [CTRL_W-1:0] KEY_A = 8'h46,
    parameter logic [CTRL_W-1:0] KEY_B = 8'h57
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output logic              armed,
    output logic              key_hit
);
    seq_regs_t r_d, r_q;

    always_comb begin
        r_d     = r_q;
        key_hit = 1'b0;
        if (wr_en) begin
            unique case (r_q.state)
                SEQ_IDLE: begin
                    if (wr_data == KEY_A) begin
                        r_d.state = SEQ_HALF;
                        key_hit   = 1'b1;
                    end
                end
                SEQ_HALF: begin
                    if (wr_data == KEY_B) begin
                        r_d.state = SEQ_ARMED;
                        key_hit   = 1'b1;
                    end else begin
                        r_d.state = SEQ_IDLE;
                    end
                end
                default: r_d.state = SEQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '{state: SEQ_IDLE};
        else        r_q <= r_d;
    end

    assign armed = (r_q.state == SEQ_ARMED);

    // R6: the armed window closes on the next control write
    a_r6_arm_once: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && wr_en) |=> !armed);

    // R4: a wrong first key never advances the sequence
    a_r4_bad_first: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == SEQ_IDLE && wr_en && wr_data != KEY_A) |=> !armed && !key_hit);
endmodule

// File: rtl/keylock_hold.sv
module keylock_hold
    import keylock_pkg::*;
#(
    parameter int LOCK_POS = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic              key_hit,
    input  logic              armed,
    input  logic              one_way,
    output logic              lock,
    output logic              ever,
    output logic [CTRL_W-1:0] ctrl_rd
);
    hold_regs_t r_d, r_q;
    logic       change_ok;

    always_comb begin
        r_d       = r_q;
        change_ok = armed && !(one_way && r_q.ever);
        if (wr_en && !key_hit) begin
            r_d.bits = wr_data;
            if (change_ok) r_d.lock = wr_data[LOCK_POS];
        end
        if (r_d.lock) r_d.ever = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '{lock: 1'b0, ever: 1'b0, bits: '0};
        else        r_q <= r_d;
    end

    always_comb begin
        ctrl_rd           = r_q.bits;
        ctrl_rd[LOCK_POS] = r_q.lock;
    end

    assign lock = r_q.lock;
    assign ever = r_q.ever;

    // R3: lock moves only on a write in the armed window
    a_r3_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && armed) |=> $stable(lock));

    // R7: one-way mode keeps a set lock set
    a_r7_one_way: assert property (@(posedge clk) disable iff (!rst_n)
        (one_way && ever) |=> lock);

    // R9: flag is sticky and covers every set lock
    a_r9_ever_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ever |=> ever);
    a_r9_lock_has_ever: assert property (@(posedge clk) disable iff (!rst_n)
        lock |-> ever);

    // R10: key writes leave the readback alone
    a_r10_key_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        key_hit |=> $stable(ctrl_rd));
endmodule

// File: rtl/keylock_guard.sv
module keylock_guard
    import keylock_pkg::*;
#(
    parameter logic [CTRL_W-1:0] KEY_FIRST  = 8'h46,
    parameter logic [CTRL_W-1:0] KEY_SECOND = 8'h57,
    parameter int                LOCK_POS   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr_en,
    input  logic [CTRL_W-1:0] ctl_wr_data,
    input  logic              one_way_en,
    input  logic              prot_wr_req,
    output logic              lock_o,
    output logic              lock_ever_o,
    output logic [CTRL_W-1:0] ctl_rd_data,
    output logic              prot_wr_ok
);
    logic armed, key_hit;

    keylock_seq #(.KEY_A(KEY_FIRST), .KEY_B(KEY_SECOND)) i_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ctl_wr_en),
        .wr_data (ctl_wr_data),
        .armed   (armed),
        .key_hit (key_hit)
    );

    keylock_hold #(.LOCK_POS(LOCK_POS)) i_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ctl_wr_en),
        .wr_data (ctl_wr_data),
        .key_hit (key_hit),
        .armed   (armed),
        .one_way (one_way_en),
        .lock    (lock_o),
        .ever    (lock_ever_o),
        .ctrl_rd (ctl_rd_data)
    );

    assign prot_wr_ok = prot_wr_req && !lock_o;
endmodule

// File: tb/test_keylock_guard.sv
module test_keylock_guard;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr_en = 1'b0;
    logic [7:0] ctl_wr_data = 8'h00;
    logic       one_way_en = 1'b0;
    logic       prot_wr_req = 1'b0;
    logic       lock_o, lock_ever_o, prot_wr_ok;
    logic [7:0] ctl_rd_data;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    keylock_guard i_keylock_guard (
        .clk(clk), .rst_n(rst_n), .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
        .one_way_en(one_way_en), .prot_wr_req(prot_wr_req), .lock_o(lock_o),
        .lock_ever_o(lock_ever_o), .ctl_rd_data(ctl_rd_data), .prot_wr_ok(prot_wr_ok)
    );

    task automatic chk(input string req, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic do_rst(input logic ow);
        @(negedge clk);
        rst_n = 1'b0; one_way_en = ow; ctl_wr_en = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        ctl_wr_en = 1'b1; ctl_wr_data = d;
        @(negedge clk);
        ctl_wr_en = 1'b0;
    endtask

    task automatic seq(input logic [7:0] d);
        wr(8'h46); wr(8'h57); wr(d);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_rst(1'b0);
        // R1 reset state
        chk("R1 lock", lock_o, 0);
        chk("R1 ever", lock_ever_o, 0);
        chk("R1 rd", ctl_rd_data, 0);

        // R2 R9 R10: every byte as the armed write
        for (int v = 0; v < 256; v++) begin
            do_rst(1'b0);
            seq(8'(v));
            chk("R2 lock from bit6", lock_o, (v >> 6) & 1);
            chk("R10 readback", ctl_rd_data, v);
            chk("R9 ever", lock_ever_o, (v >> 6) & 1);
        end

        // R4: wrong second key
        for (int v = 0; v < 256; v++) begin
            if (v == 8'h57) continue;
            do_rst(1'b0);
            wr(8'h46); wr(8'(v)); wr(8'h40);
            chk("R4 bad second key", lock_o, 0);
            chk("R10 rd after bad key", ctl_rd_data, 0);
        end
        // R4: wrong first key
        for (int v = 0; v < 256; v++) begin
            if (v == 8'h46) continue;
            do_rst(1'b0);
            wr(8'(v)); wr(8'h57); wr(8'h40);
            chk("R4 bad first key", lock_o, 0);
        end

        // R3: plain writes never move the lock
        do_rst(1'b0);
        wr(8'h40); wr(8'h57); wr(8'hFF);
        chk("R3 no sequence", lock_o, 0);
        chk("R10 non-lock bits", ctl_rd_data, 8'hBF);

        // R5: idle gaps between writes
        do_rst(1'b0);
        wr(8'h46); repeat (5) @(negedge clk);
        wr(8'h57); repeat (3) @(negedge clk);
        wr(8'h40);
        chk("R5 gaps allowed", lock_o, 1);

        // R6 R3: next write after the armed one has no lock effect
        wr(8'h00);
        chk("R6 second write", lock_o, 1);
        chk("R6 readback", ctl_rd_data, 8'h40);
        repeat (4) @(negedge clk);
        chk("R3 persists", lock_o, 1);

        // R11 while locked
        prot_wr_req = 1'b1; #1;
        chk("R11 locked masks", prot_wr_ok, 0);
        prot_wr_req = 1'b0; #1;
        chk("R11 locked idle", prot_wr_ok, 0);

        // R8 R9: repeated sessions with one-way off
        for (int k = 0; k < 3; k++) begin
            seq(8'h00);
            chk("R8 clear", lock_o, 0);
            chk("R9 ever kept", lock_ever_o, 1);
            prot_wr_req = 1'b1; #1;
            chk("R11 unlocked passes", prot_wr_ok, 1);
            prot_wr_req = 1'b0; #1;
            chk("R11 unlocked idle", prot_wr_ok, 0);
            seq(8'h40);
            chk("R8 set again", lock_o, 1);
        end

        // R7: one-way mode
        do_rst(1'b1);
        seq(8'h00);
        chk("R7 clear before set", lock_o, 0);
        chk("R9 ever still 0", lock_ever_o, 0);
        seq(8'h40);
        chk("R7 set", lock_o, 1);
        seq(8'h00);
        chk("R7 cannot clear", lock_o, 1);
        seq(8'h00);
        chk("R7 still locked", lock_o, 1);
        do_rst(1'b1);
        chk("R7 reset releases", lock_o, 0);
        chk("R1 ever after reset", lock_ever_o, 0);

        // R10: key writes leave the readback unchanged
        do_rst(1'b0);
        wr(8'h15);
        wr(8'h46);
        chk("R10 key1 quiet", ctl_rd_data, 8'h15);
        wr(8'h57);
        chk("R10 key2 quiet", ctl_rd_data, 8'h15);
        wr(8'h2A);
        chk("R10 armed write data", ctl_rd_data, 8'h2A);
        chk("R2 armed bit6 clear", lock_o, 0);

        // R4: a repeated first key is not a restart
        do_rst(1'b0);
        wr(8'h46); wr(8'h46); wr(8'h57); wr(8'h40);
        chk("R4 repeated key1", lock_o, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule